// File: doc/BRIEF.md
# Dual-Mode Parallel Host Port

This block is the processor-facing side of a serial bus controller. A host processor reaches five byte-wide registers through it, over either of two bus styles. The first style has separate active-low read and write strobes. The second has one read/write line and a chip select, and the block answers each access on a data-acknowledge output. No strap pin selects the style. The block watches the first edge on the write line after reset and locks the style it infers until the next reset.

The address bit selects between two locations. The control location is a double register: a host write lands in the control register, while a host read returns the core's status byte. The data location is also a double register: a write goes to the transmit byte, while a read returns the core's receive byte. The own-address, clock and vector setup registers sit behind the data location. They are reached by setting a two-bit page field in the control register first. The block gives the core every register value and a one-cycle strobe for each data or control write.

Every host pin passes through a two-flop synchronizer. A write is committed when the effective write strobe is released. On the read/write style, the acknowledge output drives low one clock after a synchronized access is seen and returns high once chip select is released.

Top module: `hif_host_port`

## Requirements
- R1: After reset the port is in separate-strobe mode (`mode_moto_o`=0), every register output is 0, `ack_oe_o`=0 and `ack_n_o`=1.
- R2: If the first falling edge on `wr_n_i` after reset occurs while `cs_n_i` is high, read/write mode is latched (`mode_moto_o`=1). The acknowledge output is then enabled (`ack_oe_o`=1).
- R3: If that first falling edge occurs while `cs_n_i` is low, separate-strobe mode is locked. A later `wr_n_i` fall with `cs_n_i` high does not change the mode.
- R4: In separate-strobe mode, a write is committed when `wr_n_i` rises while `cs_n_i` is low. The register update appears three clock edges after the rise reaches the pin.
- R5: In separate-strobe mode, `dout_en_o` is 1 exactly while the synchronized `cs_n_i` and `rd_n_i` are both low.
- R6: In read/write mode, `wr_n_i` low means write and high means read. A write is committed when `cs_n_i` rises. `dout_en_o` is 1 while the synchronized `cs_n_i` is low and `wr_n_i` is high. `rd_n_i` is ignored.
- R7: In read/write mode, `ack_n_o` goes low one clock after the synchronized chip select goes low, and returns high one clock after it goes high. In separate-strobe mode, `ack_n_o`=1 and `ack_oe_o`=0.
- R8: With `a0_i`=0, the page field `ctrl_o[4:3]` selects the target of both reads and writes: 00 data, 01 own-address, 10 clock, 11 vector.
- R9: The data and control locations are double registers. A write with `a0_i`=1 sets `ctrl_o`, but a read there returns `status_i`. A write to data page 00 sets `tx_data_o`, but a read there returns `rx_data_i`.
- R10: Each committed data-page write pulses `data_wr_stb_o` for one cycle, and each control write pulses `ctrl_wr_stb_o` for one cycle. The two never pulse together.
- R11: The latched mode holds until reset. A reset returns the port to separate-strobe mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Host chip select, active low |
| wr_n_i | input | 1 | Write strobe, or read/write line in read/write mode |
| rd_n_i | input | 1 | Read strobe (separate-strobe mode only) |
| a0_i | input | 1 | Address bit: 1 control/status, 0 data page |
| din_i | input | 8 | Host write data |
| dout_o | output | 8 | Host read data |
| dout_en_o | output | 1 | Drive enable for host read data |
| ack_n_o | output | 1 | Data acknowledge, active low |
| ack_oe_o | output | 1 | Output enable of the acknowledge pin |
| rx_data_i | input | 8 | Receive byte from the core |
| status_i | input | 8 | Status byte from the core |
| tx_data_o | output | 8 | Transmit byte to the core |
| ctrl_o | output | 8 | Control register |
| own_addr_o | output | 8 | Own-address setup register |
| clk_cfg_o | output | 8 | Clock setup register |
| vector_o | output | 8 | Interrupt vector setup register |
| data_wr_stb_o | output | 1 | One-cycle pulse on a data write |
| ctrl_wr_stb_o | output | 1 | One-cycle pulse on a control write |
| mode_moto_o | output | 1 | 1 when read/write mode is latched |

## Verification
The assertions check several properties on every cycle. The acknowledge stays idle and disabled outside read/write mode. Once the mode is locked it never changes. The acknowledge releases after chip select rises, and read drive occurs only under a synchronized chip select. Write strobes are single, exclusive pulses, each traced to a commit the cycle before. Only the bench's scenarios can show the rest. These are which mode the first write-line edge picks, that the page field steers writes and reads to the right setup register, and that the double registers return core values rather than written ones. They also show that the read pin is ignored in read/write mode and that reset restores separate-strobe mode.

// File: rtl/hif_pkg.sv
`timescale 1ns/1ps
package hif_pkg;
  localparam int PAGE_W = 2;

  typedef enum logic [2:0] {
    RID_DATA = 3'd0,
    RID_CTRL = 3'd1,
    RID_OWN  = 3'd2,
    RID_CLK  = 3'd3,
    RID_VEC  = 3'd4
  } reg_id_e;

  // Address bit plus page field to register target
  function automatic reg_id_e target_of(input logic a0, input logic [PAGE_W-1:0] page);
    reg_id_e t;
    if (a0) t = RID_CTRL;
    else begin
      case (page)
        2'd0:    t = RID_DATA;
        2'd1:    t = RID_OWN;
        2'd2:    t = RID_CLK;
        default: t = RID_VEC;
      endcase
    end
    return t;
  endfunction

  // Commit condition: write released, per bus style
  function automatic logic commit_of(input logic moto, input logic cs_s, input logic cs_d,
                                     input logic wr_s, input logic wr_d);
    return moto ? (cs_s & ~cs_d & ~wr_d) : (wr_s & ~wr_d & ~cs_d);
  endfunction
endpackage

// File: rtl/hif_sync.sv
`timescale 1ns/1ps
module hif_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] s_o,
  output logic [W-1:0] p_o
);
  logic [W-1:0] chain [STAGES+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i <= STAGES; i++) chain[i] <= RST_VAL;
    end else begin
      chain[0] <= d_i;
      for (int i = 1; i <= STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign s_o = chain[STAGES-1];
  assign p_o = chain[STAGES];
endmodule

// File: rtl/hif_mode_det.sv
`timescale 1ns/1ps
module hif_mode_det (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_s,
  input  logic wr_s,
  input  logic wr_d,
  output logic moto_o,
  output logic locked_o
);
  logic wr_fall;
  assign wr_fall = ~wr_s & wr_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      moto_o   <= 1'b0;
      locked_o <= 1'b0;
    end else if (!locked_o && wr_fall) begin
      moto_o   <= cs_s;
      locked_o <= 1'b1;
    end
  end
endmodule

// File: rtl/hif_access.sv
`timescale 1ns/1ps
module hif_access #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          moto_i,
  input  logic          cs_s,
  input  logic          cs_d,
  input  logic          wr_s,
  input  logic          wr_d,
  input  logic          rd_s,
  input  logic          a0_i,
  input  logic [DW-1:0] din_i,
  output logic          commit_o,
  output logic          cmt_a0_o,
  output logic [DW-1:0] cmt_data_o,
  output logic          rd_en_o,
  output logic          ack_n_o
);
  import hif_pkg::*;

  logic wr_active;
  logic ack_q;

  assign wr_active = ~cs_s & ~wr_s;
  assign commit_o  = commit_of(moto_i, cs_s, cs_d, wr_s, wr_d);
  assign rd_en_o   = moto_i ? (~cs_s & wr_s) : (~cs_s & ~rd_s);
  assign ack_n_o   = ~ack_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmt_a0_o   <= 1'b0;
      cmt_data_o <= '0;
      ack_q      <= 1'b0;
    end else begin
      if (wr_active) begin
        cmt_a0_o   <= a0_i;
        cmt_data_o <= din_i;
      end
      ack_q <= moto_i & ~cs_s;
    end
  end
endmodule

// File: rtl/hif_regfile.sv
`timescale 1ns/1ps
module hif_regfile #(
  parameter int DW = 8,
  parameter int PAGE_LSB = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          commit_i,
  input  logic          wa0_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          ra0_i,
  input  logic [DW-1:0] rx_i,
  input  logic [DW-1:0] status_i,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] tx_o,
  output logic [DW-1:0] ctrl_o,
  output logic [DW-1:0] own_o,
  output logic [DW-1:0] clk_o,
  output logic [DW-1:0] vec_o,
  output logic          data_stb_o,
  output logic          ctrl_stb_o
);
  import hif_pkg::*;

  logic [PAGE_W-1:0] page;
  reg_id_e           wtgt;
  reg_id_e           rtgt;

  assign page = ctrl_o[PAGE_LSB +: PAGE_W];
  assign wtgt = target_of(wa0_i, page);
  assign rtgt = target_of(ra0_i, page);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_o <= '0; ctrl_o <= '0; own_o <= '0; clk_o <= '0; vec_o <= '0;
      data_stb_o <= 1'b0; ctrl_stb_o <= 1'b0;
    end else begin
      data_stb_o <= 1'b0;
      ctrl_stb_o <= 1'b0;
      if (commit_i) begin
        case (wtgt)
          RID_DATA: begin tx_o <= wdata_i; data_stb_o <= 1'b1; end
          RID_CTRL: begin ctrl_o <= wdata_i; ctrl_stb_o <= 1'b1; end
          RID_OWN:  own_o <= wdata_i;
          RID_CLK:  clk_o <= wdata_i;
          default:  vec_o <= wdata_i;
        endcase
      end
    end
  end

  always_comb begin
    case (rtgt)
      RID_DATA: rdata_o = rx_i;
      RID_CTRL: rdata_o = status_i;
      RID_OWN:  rdata_o = own_o;
      RID_CLK:  rdata_o = clk_o;
      default:  rdata_o = vec_o;
    endcase
  end
endmodule

// File: rtl/hif_host_port.sv
`timescale 1ns/1ps
module hif_host_port #(
  parameter int DW = 8,
  parameter int SYNC_STAGES = 2,
  parameter int PAGE_LSB = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n_i,
  input  logic          wr_n_i,
  input  logic          rd_n_i,
  input  logic          a0_i,
  input  logic [DW-1:0] din_i,
  output logic [DW-1:0] dout_o,
  output logic          dout_en_o,
  output logic          ack_n_o,
  output logic          ack_oe_o,
  input  logic [DW-1:0] rx_data_i,
  input  logic [DW-1:0] status_i,
  output logic [DW-1:0] tx_data_o,
  output logic [DW-1:0] ctrl_o,
  output logic [DW-1:0] own_addr_o,
  output logic [DW-1:0] clk_cfg_o,
  output logic [DW-1:0] vector_o,
  output logic          data_wr_stb_o,
  output logic          ctrl_wr_stb_o,
  output logic          mode_moto_o
);
  localparam int NPIN = 3;

  logic [NPIN-1:0] pin_s, pin_d;
  logic cs_s_w, cs_d_w, wr_s_w, wr_d_w, rd_s_w;
  logic locked_w, commit_w, cmt_a0_w;
  logic [DW-1:0] cmt_data_w;

  hif_sync #(.W(NPIN), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i({cs_n_i, wr_n_i, rd_n_i}), .s_o(pin_s), .p_o(pin_d)
  );

  assign {cs_s_w, wr_s_w, rd_s_w} = pin_s;
  assign cs_d_w = pin_d[2];
  assign wr_d_w = pin_d[1];

  hif_mode_det u_mode (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s_w), .wr_s(wr_s_w), .wr_d(wr_d_w),
    .moto_o(mode_moto_o), .locked_o(locked_w)
  );

  hif_access #(.DW(DW)) u_acc (
    .clk(clk), .rst_n(rst_n), .moto_i(mode_moto_o),
    .cs_s(cs_s_w), .cs_d(cs_d_w), .wr_s(wr_s_w), .wr_d(wr_d_w), .rd_s(rd_s_w),
    .a0_i(a0_i), .din_i(din_i),
    .commit_o(commit_w), .cmt_a0_o(cmt_a0_w), .cmt_data_o(cmt_data_w),
    .rd_en_o(dout_en_o), .ack_n_o(ack_n_o)
  );

  assign ack_oe_o = mode_moto_o;

  hif_regfile #(.DW(DW), .PAGE_LSB(PAGE_LSB)) u_regs (
    .clk(clk), .rst_n(rst_n), .commit_i(commit_w), .wa0_i(cmt_a0_w), .wdata_i(cmt_data_w),
    .ra0_i(a0_i), .rx_i(rx_data_i), .status_i(status_i), .rdata_o(dout_o),
    .tx_o(tx_data_o), .ctrl_o(ctrl_o), .own_o(own_addr_o), .clk_o(clk_cfg_o), .vec_o(vector_o),
    .data_stb_o(data_wr_stb_o), .ctrl_stb_o(ctrl_wr_stb_o)
  );
endmodule

// File: rtl/hif_host_port_chk.sv
`timescale 1ns/1ps
module hif_host_port_chk (
  input logic clk,
  input logic rst_n,
  input logic moto,
  input logic locked,
  input logic cs_s,
  input logic commit,
  input logic dout_en,
  input logic ack_n,
  input logic ack_oe,
  input logic data_stb,
  input logic ctrl_stb
);
  // R7
  no_ack_outside_rw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !moto |-> (ack_n && !ack_oe));
  // R11
  mode_lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> (locked && $stable(moto)));
  // R7
  ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> ack_n);
  // R5
  read_needs_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dout_en |-> !cs_s);
  // R10
  stb_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_stb || ctrl_stb) |=> !(data_stb || ctrl_stb));
  // R10
  stb_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({data_stb, ctrl_stb}));
  // R4
  stb_after_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_stb || ctrl_stb) |-> $past(commit));
endmodule

bind hif_host_port hif_host_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .moto(mode_moto_o), .locked(locked_w), .cs_s(cs_s_w),
  .commit(commit_w), .dout_en(dout_en_o), .ack_n(ack_n_o), .ack_oe(ack_oe_o),
  .data_stb(data_wr_stb_o), .ctrl_stb(ctrl_wr_stb_o)
);

// File: tb/sim_hif_host_port.sv
`timescale 1ns/1ps
module sim_hif_host_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, a0 = 1'b0;
  logic [7:0] din = 8'h00;
  logic [7:0] rx = 8'hC3, status = 8'h81;
  logic [7:0] dout, tx, ctrl, own, clkc, vec;
  logic dout_en, ack_n, ack_oe, dstb, cstb, moto;

  always #10 clk = ~clk;

  hif_host_port u0 (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .wr_n_i(wr_n), .rd_n_i(rd_n), .a0_i(a0),
    .din_i(din), .dout_o(dout), .dout_en_o(dout_en), .ack_n_o(ack_n), .ack_oe_o(ack_oe),
    .rx_data_i(rx), .status_i(status), .tx_data_o(tx), .ctrl_o(ctrl), .own_addr_o(own),
    .clk_cfg_o(clkc), .vector_o(vec), .data_wr_stb_o(dstb), .ctrl_wr_stb_o(cstb),
    .mode_moto_o(moto)
  );

  int vectors = 0;
  int errors = 0;

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %02h expected %02h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Behavioural reference: pin history queue, two-edge sync latency
  typedef struct packed { logic cs; logic wr; logic rd; logic a0; logic [7:0] din; } pins_t;
  localparam pins_t IDLE = '{cs: 1'b1, wr: 1'b1, rd: 1'b1, a0: 1'b0, din: 8'h00};
  pins_t hist[$];
  logic m_moto, m_lock, m_ack, m_dstb, m_cstb;
  logic [7:0] m_tx, m_ctrl, m_own, m_clk, m_vec;

  always @(posedge clk) begin : model
    pins_t s, d;
    logic cmt, nack;
    if (!rst_n) begin
      hist = {IDLE, IDLE, IDLE, IDLE};
      m_moto = 0; m_lock = 0; m_ack = 0; m_dstb = 0; m_cstb = 0;
      m_tx = 0; m_ctrl = 0; m_own = 0; m_clk = 0; m_vec = 0;
    end else begin
      hist.push_front('{cs: cs_n, wr: wr_n, rd: rd_n, a0: a0, din: din});
      void'(hist.pop_back());
      s = hist[2]; d = hist[3];
      if (m_moto) cmt = s.cs && !d.cs && !d.wr;
      else        cmt = s.wr && !d.wr && !d.cs;
      nack = m_moto && !s.cs;
      m_dstb = 0; m_cstb = 0;
      if (cmt) begin
        if (hist[1].a0) begin m_ctrl = hist[1].din; m_cstb = 1; end
        else case (m_ctrl[4:3])
          2'd0: begin m_tx = hist[1].din; m_dstb = 1; end
          2'd1: m_own = hist[1].din;
          2'd2: m_clk = hist[1].din;
          default: m_vec = hist[1].din;
        endcase
      end
      if (!m_lock && !s.wr && d.wr) begin m_moto = s.cs; m_lock = 1; end
      m_ack = nack;
    end
  end

  always @(negedge clk) begin
    logic e_en;
    logic [7:0] e_do;
    if (rst_n && hist.size() == 4) begin
      e_en = m_moto ? (!hist[1].cs && hist[1].wr) : (!hist[1].cs && !hist[1].rd);
      if (a0) e_do = status;
      else case (m_ctrl[4:3])
        2'd0: e_do = rx; 2'd1: e_do = m_own; 2'd2: e_do = m_clk; default: e_do = m_vec;
      endcase
      chk("R2", "mode", {7'd0, moto}, {7'd0, m_moto});
      chk("R7", "ack_n", {7'd0, ack_n}, {7'd0, !m_ack});
      chk("R7", "ack_oe", {7'd0, ack_oe}, {7'd0, m_moto});
      chk("R5", "dout_en", {7'd0, dout_en}, {7'd0, e_en});
      if (e_en) chk("R9", "dout", dout, e_do);
      chk("R9", "tx", tx, m_tx);
      chk("R4", "ctrl", ctrl, m_ctrl);
      chk("R8", "own", own, m_own);
      chk("R8", "clk", clkc, m_clk);
      chk("R8", "vec", vec, m_vec);
      chk("R10", "strobes", {6'd0, dstb, cstb}, {6'd0, m_dstb, m_cstb});
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 0; cs_n = 1; wr_n = 1; rd_n = 1; a0 = 0; din = 0;
    tick(3);
    rst_n = 1;
    tick(2);
  endtask

  task automatic sep_write(input logic ad, input logic [7:0] v);
    a0 = ad; din = v; cs_n = 0; tick(2);
    wr_n = 0; tick(4);
    wr_n = 1; tick(4);
    cs_n = 1; tick(3);
  endtask

  task automatic sep_read(input logic ad, input logic [7:0] exp, input string req);
    a0 = ad; cs_n = 0; rd_n = 0; tick(4);
    @(negedge clk);
    chk(req, "read enable", {7'd0, dout_en}, 8'd1);
    chk(req, "read data", dout, exp);
    tick(1);
    rd_n = 1; cs_n = 1; tick(3);
  endtask

  task automatic rw_write(input logic ad, input logic [7:0] v);
    a0 = ad; din = v; wr_n = 0; tick(2);
    cs_n = 0; rd_n = 0; tick(4);
    @(negedge clk);
    // R6: read pin low during a write has no effect on read drive
    chk("R6", "rd pin ignored", {7'd0, dout_en}, 8'd0);
    // R7: acknowledge asserted during access
    chk("R7", "ack low", {7'd0, ack_n}, 8'd0);
    tick(1);
    cs_n = 1; rd_n = 1; tick(4);
    chk("R7", "ack released", {7'd0, ack_n}, 8'd1);
    wr_n = 1; tick(2);
  endtask

  task automatic rw_read(input logic ad, input logic [7:0] exp);
    a0 = ad; wr_n = 1; cs_n = 0; tick(4);
    @(negedge clk);
    chk("R6", "rw read enable", {7'd0, dout_en}, 8'd1);
    chk("R6", "rw read data", dout, exp);
    tick(1);
    cs_n = 1; tick(4);
  endtask

  initial begin
    do_reset();
    @(negedge clk);
    chk("R1", "reset mode", {7'd0, moto}, 8'd0);
    chk("R1", "reset ack_oe", {7'd0, ack_oe}, 8'd0);
    chk("R1", "reset ack_n", {7'd0, ack_n}, 8'd1);
    chk("R1", "reset tx", tx, 8'd0);
    chk("R1", "reset ctrl", ctrl, 8'd0);
    tick(1);

    // Separate-strobe session
    sep_write(1'b0, 8'h5A);
    chk("R3", "mode after first write", {7'd0, moto}, 8'd0);
    chk("R4", "tx committed", tx, 8'h5A);
    sep_read(1'b0, 8'hC3, "R9");
    sep_read(1'b1, 8'h81, "R9");
    sep_write(1'b1, 8'h08);
    chk("R9", "ctrl written", ctrl, 8'h08);
    sep_write(1'b0, 8'h37);
    chk("R8", "own via page 01", own, 8'h37);
    chk("R8", "tx untouched", tx, 8'h5A);
    sep_read(1'b0, 8'h37, "R8");
    sep_write(1'b1, 8'h10);
    sep_write(1'b0, 8'h1C);
    chk("R8", "clock via page 10", clkc, 8'h1C);
    sep_write(1'b1, 8'h18);
    sep_write(1'b0, 8'hE2);
    chk("R8", "vector via page 11", vec, 8'hE2);
    sep_read(1'b0, 8'hE2, "R8");
    sep_read(1'b1, 8'h81, "R9");
    // R3: later write fall with chip select high keeps mode
    wr_n = 0; tick(4); wr_n = 1; tick(4);
    chk("R3", "mode kept", {7'd0, moto}, 8'd0);
    chk("R7", "no ack in sep mode", {7'd0, ack_oe}, 8'd0);

    // Read/write session
    do_reset();
    rw_write(1'b0, 8'hA5);
    chk("R2", "rw mode latched", {7'd0, moto}, 8'd1);
    chk("R2", "ack enabled", {7'd0, ack_oe}, 8'd1);
    chk("R6", "rw data write", tx, 8'hA5);
    rw_read(1'b0, 8'hC3);
    rw_read(1'b1, 8'h81);
    rw_write(1'b1, 8'h08);
    rw_write(1'b0, 8'h6B);
    chk("R8", "rw own write", own, 8'h6B);
    rw_read(1'b0, 8'h6B);
    chk("R11", "mode holds", {7'd0, moto}, 8'd1);
    do_reset();
    @(negedge clk);
    chk("R11", "reset restores sep mode", {7'd0, moto}, 8'd0);
    chk("R1", "reset clears own", own, 8'd0);
    tick(2);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule